// File: doc/BRIEF.md
# Multi-level priority interrupt controller

This block gathers interrupt request pulses from up to 54 peripheral sources and chooses which one, if any, should pre-empt the processor core. Every source owns a sticky pending flag, an enable bit and a three-bit priority. Software reaches all three through a small register port. A separate control register holds the running CPU priority level, a nesting-disable switch and a selector for the alternate vector table.

Each cycle the arbiter looks only at sources that are flagged and enabled. It picks the highest priority among them, and the lowest index breaks a tie. A take request is raised when the winner's priority is strictly above the CPU level. The core answers with an acknowledge. The block then records the old level for the core to save, raises the CPU level to the winner's priority (or to 7 when nesting is disabled), and leaves the flag for the handler to clear. A return input puts a saved level back. A wake output lets a sleeping core resume whenever any enabled source is flagged, whatever its priority.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A flagged, enabled source whose priority is 0 never causes `take_req`.
- R2: `take_req` is 1 exactly when some flagged, enabled source has a priority strictly greater than `cpu_lvl`.
- R3: After reset all flags and enables are 0, every priority is 4, `cpu_lvl` and `prev_lvl` are 0, and nesting-disable and alternate-table are off.
- R4: `take_vec` gives the index of the flagged, enabled source with the highest priority. Among equal priorities the lowest index wins.
- R5: A request pulse sets the source's flag whether or not the source is enabled and whatever its priority. Source register i (address i, for i below 54) reads as bit 0 flag, bit 1 enable, bits 4:2 priority.
- R6: When `take_ack` is 1 while `take_req` is 1, on the next clock `prev_lvl` takes the old `cpu_lvl` and `cpu_lvl` takes the winner's priority. Other sources pending at that level then do not raise `take_req`.
- R7: With nesting disabled, an accepted interrupt sets `cpu_lvl` to 7. Software writes to the level field are ignored while nesting is disabled.
- R8: `wake` is 1 whenever any source is both flagged and enabled, at any priority.
- R9: `take_slot` equals `take_vec` when the alternate-table bit is 0, and `take_vec` + 54 when it is 1.
- R10: `ret_req` loads `cpu_lvl` from `ret_lvl` on the next clock. An accepted interrupt in the same cycle takes precedence.
- R11: Writing a 0 to a flag bit clears it unless that source's request arrives in the same cycle, in which case the flag stays 1. Writing a 1 leaves the flag unchanged.
- R12: The control register at address 64 reads and writes bits 2:0 level, bit 3 nesting-disable and bit 4 alternate-table. Addresses 54 to 63 and 65 to 127 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | 54 | Per-source request pulses |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register address |
| reg_wdata | input | 5 | Register write data |
| reg_rdata | output | 5 | Register read data for `reg_addr` |
| take_req | output | 1 | An interrupt should be taken |
| take_vec | output | 6 | Winning source index |
| take_slot | output | 7 | Vector slot, including the table offset |
| take_ack | input | 1 | Core accepts the current winner |
| prev_lvl | output | 3 | CPU level held before the last acceptance |
| ret_req | input | 1 | Return from handler |
| ret_lvl | input | 3 | Level to restore on return |
| cpu_lvl | output | 3 | Current CPU priority level |
| wake | output | 1 | Some enabled source is flagged |

## Verification
Directed patterns come first. Two equal-priority sources pending together show whether ties go to the lower index. A later source with higher priority shows that priority outranks index. A priority-0 source that is enabled separates wake from take. Write-clear and request are put in the same cycle to confirm the request wins. The nesting-disable sequence checks that acceptance pins the level at 7 and that software cannot lower it. A long run of random requests, writes, acknowledges and returns is then compared each clock against a behavioural model. This mix catches ordering errors between acknowledge, return and software writes.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_TOP = 3'd7;
  localparam lvl_t LVL_RST = 3'd4;
  localparam int DATA_W = 5;

  function automatic logic lvl_above(lvl_t cand, lvl_t cur);
    return cand > cur;
  endfunction
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_pkg::*;
#(
  parameter int N      = 54,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      src_req,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_flag,
  input  logic              wr_enable,
  input  lvl_t              wr_prio,
  output logic [N-1:0]      flag_q,
  output logic [N-1:0]      en_q,
  output logic [N*LVL_W-1:0] prio_flat
);
  for (genvar i = 0; i < N; i++) begin : g_src
    logic hit;
    logic clr;
    lvl_t prio_q;
    assign hit = wr_en && (wr_addr == ADDR_W'(i));
    assign clr = hit && !wr_flag;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[i] <= 1'b0;
        en_q[i]   <= 1'b0;
        prio_q    <= LVL_RST;
      end else begin
        flag_q[i] <= src_req[i] | (flag_q[i] & ~clr);
        if (hit) begin
          en_q[i] <= wr_enable;
          prio_q  <= wr_prio;
        end
      end
    end
    assign prio_flat[i*LVL_W +: LVL_W] = prio_q;
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int N     = 54,
  parameter int IDX_W = 6
) (
  input  logic [N-1:0]       flag_q,
  input  logic [N-1:0]       en_q,
  input  logic [N*LVL_W-1:0] prio_flat,
  output logic               win_valid,
  output logic [IDX_W-1:0]   win_idx,
  output lvl_t               win_prio,
  output logic               any_live
);
  logic [N-1:0] live;
  assign live     = flag_q & en_q;
  assign any_live = |live;

  always_comb begin
    win_prio = '0;
    win_idx  = '0;
    for (int i = 0; i < N; i++) begin
      if (live[i] && lvl_above(prio_flat[i*LVL_W +: LVL_W], win_prio)) begin
        win_prio = prio_flat[i*LVL_W +: LVL_W];
        win_idx  = IDX_W'(i);
      end
    end
  end
  assign win_valid = (win_prio != '0);
endmodule

// File: rtl/irq_level_ctl.sv
module irq_level_ctl
  import irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic take_fire,
  input  lvl_t win_prio,
  input  logic ret_req,
  input  lvl_t ret_lvl,
  input  logic ctrl_wr,
  input  lvl_t wr_lvl,
  input  logic wr_nest,
  input  logic wr_alt,
  output lvl_t cpu_lvl,
  output lvl_t prev_lvl,
  output logic nest_dis,
  output logic alt_sel
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_lvl  <= '0;
      prev_lvl <= '0;
      nest_dis <= 1'b0;
      alt_sel  <= 1'b0;
    end else begin
      if (take_fire) begin
        prev_lvl <= cpu_lvl;
        cpu_lvl  <= nest_dis ? LVL_TOP : win_prio;
      end else if (ret_req) begin
        cpu_lvl <= ret_lvl;
      end else if (ctrl_wr && !nest_dis) begin
        cpu_lvl <= wr_lvl;
      end
      if (ctrl_wr) begin
        nest_dis <= wr_nest;
        alt_sel  <= wr_alt;
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 54
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_SRC-1:0]           src_req,
  input  logic                         reg_we,
  input  logic [$clog2(NUM_SRC):0]     reg_addr,
  input  logic [4:0]                   reg_wdata,
  output logic [4:0]                   reg_rdata,
  output logic                         take_req,
  output logic [$clog2(NUM_SRC)-1:0]   take_vec,
  output logic [$clog2(NUM_SRC):0]     take_slot,
  input  logic                         take_ack,
  output logic [2:0]                   prev_lvl,
  input  logic                         ret_req,
  input  logic [2:0]                   ret_lvl,
  output logic [2:0]                   cpu_lvl,
  output logic                         wake
);
  localparam int IDX_W  = $clog2(NUM_SRC);
  localparam int ADDR_W = IDX_W + 1;
  localparam int SLOT_W = IDX_W + 1;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(1 << IDX_W);

  function automatic logic [SLOT_W-1:0] slot_of(logic [IDX_W-1:0] idx, logic alt);
    return SLOT_W'(idx) + (alt ? SLOT_W'(NUM_SRC) : SLOT_W'(0));
  endfunction

  logic [NUM_SRC-1:0]       flags;
  logic [NUM_SRC-1:0]       enables;
  logic [NUM_SRC*LVL_W-1:0] prio_flat;
  logic                     win_valid;
  logic [IDX_W-1:0]         win_idx;
  lvl_t                     win_prio;
  logic                     any_live;
  logic                     take_fire;
  logic                     ctrl_wr;
  logic                     nest_dis;
  logic                     alt_sel;
  lvl_t                     cpu_lvl_q;
  lvl_t                     prev_lvl_q;
  logic [IDX_W-1:0]         rd_idx;

  irq_src_bank #(.N(NUM_SRC), .ADDR_W(ADDR_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_req   (src_req),
    .wr_en     (reg_we),
    .wr_addr   (reg_addr),
    .wr_flag   (reg_wdata[0]),
    .wr_enable (reg_wdata[1]),
    .wr_prio   (reg_wdata[4:2]),
    .flag_q    (flags),
    .en_q      (enables),
    .prio_flat (prio_flat)
  );

  irq_arbiter #(.N(NUM_SRC), .IDX_W(IDX_W)) u_arb (
    .flag_q    (flags),
    .en_q      (enables),
    .prio_flat (prio_flat),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .win_prio  (win_prio),
    .any_live  (any_live)
  );

  assign take_req  = win_valid && lvl_above(win_prio, cpu_lvl_q);
  assign take_fire = take_req && take_ack;
  assign ctrl_wr   = reg_we && (reg_addr == CTRL_ADDR);

  irq_level_ctl u_lvl (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_fire (take_fire),
    .win_prio  (win_prio),
    .ret_req   (ret_req),
    .ret_lvl   (ret_lvl),
    .ctrl_wr   (ctrl_wr),
    .wr_lvl    (reg_wdata[2:0]),
    .wr_nest   (reg_wdata[3]),
    .wr_alt    (reg_wdata[4]),
    .cpu_lvl   (cpu_lvl_q),
    .prev_lvl  (prev_lvl_q),
    .nest_dis  (nest_dis),
    .alt_sel   (alt_sel)
  );

  assign take_vec  = win_idx;
  assign take_slot = slot_of(win_idx, alt_sel);
  assign cpu_lvl   = cpu_lvl_q;
  assign prev_lvl  = prev_lvl_q;
  assign wake      = any_live;
  assign rd_idx    = reg_addr[IDX_W-1:0];

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == CTRL_ADDR) begin
      reg_rdata = {alt_sel, nest_dis, cpu_lvl_q};
    end else if (reg_addr < ADDR_W'(NUM_SRC)) begin
      reg_rdata = {prio_flat[rd_idx*LVL_W +: LVL_W], enables[rd_idx], flags[rd_idx]};
    end
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int N     = 54,
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             take_req,
  input logic             take_fire,
  input logic             ret_req,
  input logic [2:0]       ret_lvl,
  input logic [2:0]       cpu_lvl,
  input logic [2:0]       prev_lvl,
  input logic [2:0]       win_prio,
  input logic             nest_dis,
  input logic             wake,
  input logic [IDX_W-1:0] take_vec,
  input logic [N-1:0]     flags
);
  AST_ACK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    take_fire |=> cpu_lvl == ($past(nest_dis) ? 3'd7 : $past(win_prio))); // R6
  AST_ACK_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    take_fire |=> prev_lvl == $past(cpu_lvl)); // R6
  AST_RET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && !take_fire) |=> cpu_lvl == $past(ret_lvl)); // R10
  AST_NEST_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (nest_dis && !take_fire && !ret_req) |=> $stable(cpu_lvl)); // R7
  AST_TAKE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    take_req |-> wake); // R8
  AST_WIN_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    take_req |-> flags[take_vec]); // R4
  AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    take_req |-> win_prio != 3'd0); // R1
endmodule

bind prio_irq_ctrl irq_ctrl_chk #(.N(NUM_SRC), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .take_req  (take_req),
  .take_fire (take_fire),
  .ret_req   (ret_req),
  .ret_lvl   (ret_lvl),
  .cpu_lvl   (cpu_lvl_q),
  .prev_lvl  (prev_lvl_q),
  .win_prio  (win_prio),
  .nest_dis  (nest_dis),
  .wake      (wake),
  .take_vec  (take_vec),
  .flags     (flags)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  localparam int NS = 54;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src_req = '0;
  logic          reg_we = 1'b0;
  logic [6:0]    reg_addr = '0;
  logic [4:0]    reg_wdata = '0;
  logic [4:0]    reg_rdata;
  logic          take_req;
  logic [5:0]    take_vec;
  logic [6:0]    take_slot;
  logic          take_ack = 1'b0;
  logic [2:0]    prev_lvl;
  logic          ret_req = 1'b0;
  logic [2:0]    ret_lvl = '0;
  logic [2:0]    cpu_lvl;
  logic          wake;

  int total = 0;
  int bad = 0;
  bit done = 0;

  bit mf[NS];
  bit me[NS];
  int mp[NS];
  int m_lvl, m_prev, m_nd, m_alt;

  always #4 clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .take_req(take_req), .take_vec(take_vec), .take_slot(take_slot),
    .take_ack(take_ack), .prev_lvl(prev_lvl), .ret_req(ret_req),
    .ret_lvl(ret_lvl), .cpu_lvl(cpu_lvl), .wake(wake)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NS; i++) begin
      mf[i] = 0; me[i] = 0; mp[i] = 4;
    end
    m_lvl = 0; m_prev = 0; m_nd = 0; m_alt = 0;
  endtask

  task automatic model_best(output int best, output int idx, output bit any);
    best = 0; idx = 0; any = 0;
    for (int i = 0; i < NS; i++) begin
      if (mf[i] && me[i]) begin
        any = 1;
        if (mp[i] > best) begin best = mp[i]; idx = i; end
      end
    end
  endtask

  function automatic int model_rd(int a);
    if (a == 64) return m_alt * 16 + m_nd * 8 + m_lvl;
    if (a < NS) return mp[a] * 4 + me[a] * 2 + mf[a];
    return 0;
  endfunction

  task automatic tick();
    int best, idx, w;
    bit any, mtake, fire;
    #1;
    model_best(best, idx, any);
    mtake = best > m_lvl;
    chk(take_req == mtake, "R2 take_req", take_req, mtake);
    if (mtake) begin
      chk(take_vec == idx, "R4 take_vec", take_vec, idx);
      chk(take_slot == idx + (m_alt ? NS : 0), "R9 take_slot", take_slot, idx + (m_alt ? NS : 0));
    end
    chk(cpu_lvl == m_lvl, "R6/R7/R10 cpu_lvl", cpu_lvl, m_lvl);
    chk(prev_lvl == m_prev, "R6 prev_lvl", prev_lvl, m_prev);
    chk(wake == any, "R8 wake", wake, any);
    chk(reg_rdata == model_rd(reg_addr), "R5/R12 reg_rdata", reg_rdata, model_rd(reg_addr));
    fire = take_ack && mtake;
    w = reg_wdata;
    if (fire) begin
      m_prev = m_lvl;
      m_lvl = m_nd ? 7 : best;
    end else if (ret_req) m_lvl = ret_lvl;
    else if (reg_we && reg_addr == 64 && !m_nd) m_lvl = w % 8;
    if (reg_we && reg_addr == 64) begin
      m_nd = (w / 8) % 2; m_alt = w / 16;
    end
    for (int i = 0; i < NS; i++) begin
      bit hit;
      hit = reg_we && reg_addr == i;
      mf[i] = src_req[i] | (mf[i] & !(hit && (w % 2 == 0)));
      if (hit) begin me[i] = (w / 2) % 2; mp[i] = w / 4; end
    end
    @(negedge clk);
  endtask

  task automatic idle_in();
    src_req = '0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    take_ack = 0; ret_req = 0; ret_lvl = 0;
  endtask

  task automatic wr(int a, int d);
    reg_we = 1; reg_addr = 7'(a); reg_wdata = 5'(d);
    tick(); idle_in();
  endtask

  task automatic pulse(int i);
    src_req[i] = 1'b1; tick(); idle_in();
  endtask

  task automatic peek(int a, output int v);
    reg_addr = 7'(a); #1; v = reg_rdata;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v;
    model_reset();
    idle_in();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    peek(5, v);      chk(v == 16, "R3 reset priority 4", v, 16);
    chk(cpu_lvl == 0, "R3 reset cpu_lvl", cpu_lvl, 0);
    peek(64, v);     chk(v == 0, "R3 reset control", v, 0);
    tick();

    pulse(10);
    peek(10, v);     chk(v == 17, "R5 flag set while disabled", v, 17);
    chk(wake == 0, "R8 no wake while disabled", wake, 0);
    wr(10, 3);
    chk(wake == 1, "R8 wake at priority 0", wake, 1);
    chk(take_req == 0, "R1 priority 0 never taken", take_req, 0);
    wr(10, 2);
    chk(wake == 0, "R11 flag cleared by write 0", wake, 0);

    wr(7, 23); wr(20, 23);
    src_req[7] = 1; src_req[20] = 1; tick(); idle_in();
    chk(take_vec == 7, "R4 tie goes to lower index", take_vec, 7);
    wr(30, 27); pulse(30);
    chk(take_vec == 30, "R4 higher priority wins", take_vec, 30);
    wr(64, 16);
    chk(take_slot == 84, "R9 alternate slot", take_slot, 84);
    wr(64, 0);
    chk(take_slot == 30, "R9 primary slot", take_slot, 30);

    take_ack = 1; tick(); idle_in();
    chk(cpu_lvl == 6, "R6 level raised", cpu_lvl, 6);
    chk(prev_lvl == 0, "R6 old level output", prev_lvl, 0);
    wr(40, 27); pulse(40);
    chk(take_req == 0, "R6 same level stays pending", take_req, 0);

    ret_req = 1; ret_lvl = 0; tick(); idle_in();
    chk(cpu_lvl == 0, "R10 level restored", cpu_lvl, 0);
    chk(take_vec == 30, "R4 lowest index among level 6", take_vec, 30);

    src_req[30] = 1; reg_we = 1; reg_addr = 30; reg_wdata = 26; tick(); idle_in();
    peek(30, v);     chk(v % 2 == 1, "R11 request beats clear", v % 2, 1);
    wr(30, 26);
    peek(30, v);     chk(v % 2 == 0, "R11 clear alone", v % 2, 0);
    chk(take_vec == 40, "R4 next winner", take_vec, 40);

    wr(64, 8);
    take_ack = 1; tick(); idle_in();
    chk(cpu_lvl == 7, "R7 nesting off forces 7", cpu_lvl, 7);
    wr(64, 10);
    chk(cpu_lvl == 7, "R7 level write ignored", cpu_lvl, 7);
    peek(64, v);     chk(v == 15, "R12 control readback", v, 15);
    peek(60, v);     chk(v == 0, "R12 unmapped reads 0", v, 0);
    ret_req = 1; ret_lvl = 0; tick(); idle_in();
    chk(cpu_lvl == 0, "R10 return under nesting off", cpu_lvl, 0);
    wr(64, 0);

    for (int c = 0; c < 3000; c++) begin
      for (int i = 0; i < NS; i++) src_req[i] = ($urandom % 40) == 0;
      reg_we    = ($urandom % 5) == 0;
      reg_addr  = 7'($urandom % 72);
      reg_wdata = 5'($urandom);
      take_ack  = ($urandom % 4) == 0;
      ret_req   = ($urandom % 8) == 0;
      ret_lvl   = 3'($urandom);
      tick();
    end
    idle_in();
    tick();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule